// File: doc/BRIEF.md
# Two-Share Byte-Serial AES-128 Key Schedule

This block keeps an AES-128 round key as sixteen bytes, with every byte split into two Boolean shares whose XOR is the real value. An external round sequencer drives a cycle index from 1 to 23 for each round. In cycles 1 to 16 the block presents one round-key byte per cycle, in two shares, to the data path. The bytes come column by column, and within a column from row 0 to row 3. In the later cycles it works out the next round key. It sends the rotated last column, one byte at a time, to an external shared S-box. Before each byte goes out it becomes three shares, using a fresh random byte. The S-box returns three shares, which the block folds back into two as it merges them into the first column.

The XOR chain for the remaining columns does not need a pass of its own. Each byte is completed while it is shifted out in the following round: a byte from column one onward is XORed with the updated byte four positions behind it. The shares are written back into the tail with a fresh random refresh. A cycle index of zero is an idle cycle, and the sequencer may insert idle cycles between phases.

Top module: `kexp_share2`

## Requirements
- R1: After reset, and while `cyc_i` is 0, `rk_valid_o`, both round-key shares and all three S-box input shares are zero.
- R2: When `first_i` is 1, in cycle c (1..16) `rk_valid_o` is 1 and `rk_s0 ^ rk_s1` equals `key_in_s0 ^ key_in_s1`. The key is loaded byte b = c-1, with byte b standing at row b mod 4 and column b div 4.
- R3: In every later round, in cycle c (1..16) the XOR of the round-key shares equals byte c-1, in the same column-major order, of the next AES-128 expanded round key. This holds whatever the random and mask values are.
- R4: In cycles 18, 19, 20 and 21, the XOR of the three S-box input shares equals the byte at row 1, 2, 3 and 0 of the last column of the key emitted in that round. In all other cycles the S-box inputs are zero.
- R5: In cycles 18 to 21, `sb_in_s2` equals `rnd_i`, the fresh share used to expand the byte to three shares.
- R6: The round constant is 01 for the first key computed after a round with `first_i` set. It is doubled in GF(2^8) after each use, returns from 36 to 01, and is XORed only into row 0, in cycle 20.
- R7: A cycle with `cyc_i` equal to 0 leaves the stored key unchanged, whatever values `first_i`, `key_in_*` and `rnd_i` carry.
- R8: The S-box result shares present in cycles 20 to 23 are reduced to two shares and XORed into rows 0 to 3 of column 0. They appear as the first four bytes of the next round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_i | input | 5 | Cycle index within the round, 1..23; 0 means idle |
| first_i | input | 1 | Marks the round in which the cipher key is loaded |
| key_in_s0 | input | 8 | Cipher-key byte, share 0 |
| key_in_s1 | input | 8 | Cipher-key byte, share 1 |
| rnd_i | input | 8 | Fresh random byte for each cycle |
| sb_out_s0 | input | 8 | S-box result, share 0 |
| sb_out_s1 | input | 8 | S-box result, share 1 |
| sb_out_s2 | input | 8 | S-box result, share 2 |
| sb_in_s0 | output | 8 | S-box operand, share 0 |
| sb_in_s1 | output | 8 | S-box operand, share 1 |
| sb_in_s2 | output | 8 | S-box operand, share 2 (fresh) |
| rk_valid_o | output | 1 | Round-key byte valid (cycles 1..16) |
| rk_s0 | output | 8 | Round-key byte, share 0 |
| rk_s1 | output | 8 | Round-key byte, share 1 |

## Verification
The bench builds the block with its defaults: a 23-cycle round and an S-box latency of two cycles. With these values, feeding starts in cycle 18 and merging in cycle 20. The bench's S-box model can therefore return three fresh-masked shares in exactly the cycles the merge window expects. Twelve round keys per run go past the tenth round constant, so the wrap from 36 back to 01 can be observed at the ports. A partial run followed by a new load shows that the round constant restarts. Idle gaps placed after cycle 16 and after cycle 23, with random values on the unused inputs, test the hold behaviour.

// File: rtl/kexp_pkg.sv
// Shared types and helpers for the two-share key schedule.
// Assumes byte-wide shares and the AES field polynomial x^8+x^4+x^3+x+1.
package kexp_pkg;
    localparam int BYTE_W = 8;
    localparam int ROWS   = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] s1;
        logic [BYTE_W-1:0] s0;
    } share_byte_t;

    // Multiply by x in GF(2^8).
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] v);
        return {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? 8'h1b : 8'h00);
    endfunction
endpackage

// File: rtl/kexp_phase.sv
// Decodes the external cycle index into the phase strobes of the schedule.
// Assumes cyc_i counts 1..ROUND_LEN within a round and 0 marks an idle cycle.
module kexp_phase #(
    parameter int ROUND_LEN = 23,
    parameter int SBOX_LAT  = 2,
    parameter int KEY_BYTES = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cyc_i,
    input  logic             first_i,
    output logic             emit_o,
    output logic             chain_o,
    output logic             feed_o,
    output logic [1:0]       feed_row_o,
    output logic             merge_o,
    output logic [1:0]       merge_row_o,
    output logic             rc_fire_o,
    output logic             rc_load_o
);
    import kexp_pkg::*;

    localparam int FEED_FIRST  = ROUND_LEN - (ROWS - 1) - SBOX_LAT;
    localparam int MERGE_FIRST = FEED_FIRST + SBOX_LAT;
    localparam int CHAIN_FIRST = ROWS + 1;

    logic [CNT_W-1:0] feed_off;
    logic [CNT_W-1:0] merge_off;

    // Window decode for emission, feed and merge phases.
    always_comb begin
        emit_o    = (cyc_i >= CNT_W'(1)) && (cyc_i <= CNT_W'(KEY_BYTES));
        chain_o   = emit_o && (cyc_i >= CNT_W'(CHAIN_FIRST));
        feed_o    = (cyc_i >= CNT_W'(FEED_FIRST)) &&
                    (cyc_i <= CNT_W'(FEED_FIRST + ROWS - 1));
        merge_o   = (cyc_i >= CNT_W'(MERGE_FIRST)) &&
                    (cyc_i <= CNT_W'(MERGE_FIRST + ROWS - 1));
        feed_off  = cyc_i - CNT_W'(FEED_FIRST);
        merge_off = cyc_i - CNT_W'(MERGE_FIRST);
        feed_row_o  = feed_off[1:0] + 2'd1;
        merge_row_o = merge_off[1:0];
        rc_fire_o = (cyc_i == CNT_W'(MERGE_FIRST));
        rc_load_o = first_i && (cyc_i == CNT_W'(1));
    end

    // R4: feeding never overlaps round-key emission.
    a_r4_feed_not_emit: assert property (@(posedge clk) disable iff (!rst_n)
        feed_o |-> !emit_o);
endmodule

// File: rtl/kexp_rcon.sv
// Round-constant register: reloads to 01 on a key load, advances after each use.
// Assumes at most one use per round; wraps from 36 back to 01.
module kexp_rcon (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rc_load_i,
    input  logic       rc_fire_i,
    output logic [7:0] rcon_o
);
    import kexp_pkg::*;

    logic [7:0] rcon_q;

    // Holds the constant for the next key computation.
    always_ff @(posedge clk) begin
        if (!rst_n)          rcon_q <= 8'h01;
        else if (rc_load_i)  rcon_q <= 8'h01;
        else if (rc_fire_i)  rcon_q <= (rcon_q == 8'h36) ? 8'h01 : gf_dbl(rcon_q);
    end

    assign rcon_o = rcon_q;

    // R6: the constant is always one of the ten legal values.
    a_r6_rcon_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rcon_q inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40,
                       8'h80, 8'h1b, 8'h36});
    // R6: a key load restarts the sequence.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rc_load_i |=> rcon_q == 8'h01);
endmodule

// File: rtl/kexp_array.sv
// Sixteen two-share key bytes: shift toward byte 0 while emitting, otherwise hold,
// except for the column-0 row that takes the merged S-box result.
// Assumes emit and merge are never active together.
module kexp_array #(
    parameter int KEY_BYTES = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                emit_i,
    input  logic                                merge_i,
    input  logic [1:0]                          merge_row_i,
    input  kexp_pkg::share_byte_t               tail_i,
    input  kexp_pkg::share_byte_t               mix_i,
    output kexp_pkg::share_byte_t [KEY_BYTES-1:0] key_o
);
    import kexp_pkg::*;

    share_byte_t [KEY_BYTES-1:0] key_q;

    for (genvar j = 0; j < KEY_BYTES; j++) begin : g_byte
        share_byte_t nxt;
        if (j == KEY_BYTES - 1) begin : g_tail
            assign nxt = tail_i;
        end else begin : g_mid
            assign nxt = key_q[j+1];
        end

        if (j < ROWS) begin : g_col0
            // Column-0 byte: shift, or absorb the S-box result for its row.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    key_q[j] <= '0;
                else if (emit_i)
                    key_q[j] <= nxt;
                else if (merge_i && (merge_row_i == 2'(j)))
                    key_q[j] <= key_q[j] ^ mix_i;
            end
        end else begin : g_rest
            // Other byte: shift during emission only.
            always_ff @(posedge clk) begin
                if (!rst_n)      key_q[j] <= '0;
                else if (emit_i) key_q[j] <= nxt;
            end
        end
    end

    assign key_o = key_q;
endmodule

// File: rtl/kexp_share2.sv
// Two-share byte-serial AES-128 key schedule.
// Emits one round-key byte per cycle in cycles 1..16, feeds the rotated last column
// to an external S-box in three shares and merges its result into column 0.
// Assumes the external S-box has exactly SBOX_LAT cycles of latency.
module kexp_share2 #(
    parameter int ROUND_LEN = 23,
    parameter int SBOX_LAT  = 2,
    parameter int CNT_W     = $clog2(ROUND_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cyc_i,
    input  logic             first_i,
    input  logic [7:0]       key_in_s0,
    input  logic [7:0]       key_in_s1,
    input  logic [7:0]       rnd_i,
    input  logic [7:0]       sb_out_s0,
    input  logic [7:0]       sb_out_s1,
    input  logic [7:0]       sb_out_s2,
    output logic [7:0]       sb_in_s0,
    output logic [7:0]       sb_in_s1,
    output logic [7:0]       sb_in_s2,
    output logic             rk_valid_o,
    output logic [7:0]       rk_s0,
    output logic [7:0]       rk_s1
);
    import kexp_pkg::*;

    localparam int KEY_BYTES = 16;
    localparam int LAST_COL  = KEY_BYTES - ROWS;
    localparam int IDX_W     = $clog2(KEY_BYTES);

    logic emit, chain, feed, merge, rc_fire, rc_load;
    logic [1:0] feed_row, merge_row;
    logic [7:0] rcon;
    share_byte_t [KEY_BYTES-1:0] key_q;
    share_byte_t cur_b, tail_b, mix_b, feed_b;
    logic [IDX_W-1:0] feed_idx;

    kexp_phase #(
        .ROUND_LEN(ROUND_LEN), .SBOX_LAT(SBOX_LAT),
        .KEY_BYTES(KEY_BYTES), .CNT_W(CNT_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .first_i(first_i),
        .emit_o(emit), .chain_o(chain), .feed_o(feed), .feed_row_o(feed_row),
        .merge_o(merge), .merge_row_o(merge_row),
        .rc_fire_o(rc_fire), .rc_load_o(rc_load)
    );

    kexp_rcon u_rcon (
        .clk(clk), .rst_n(rst_n), .rc_load_i(rc_load), .rc_fire_i(rc_fire),
        .rcon_o(rcon)
    );

    kexp_array #(.KEY_BYTES(KEY_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .emit_i(emit), .merge_i(merge),
        .merge_row_i(merge_row), .tail_i(tail_b), .mix_i(mix_b), .key_o(key_q)
    );

    // Current round-key byte: head byte, chained with the updated byte one column back.
    always_comb begin
        if (first_i) begin
            cur_b.s0 = key_in_s0;
            cur_b.s1 = key_in_s1;
        end else begin
            cur_b.s0 = key_q[0].s0 ^ (chain ? key_q[LAST_COL].s0 : 8'h00);
            cur_b.s1 = key_q[0].s1 ^ (chain ? key_q[LAST_COL].s1 : 8'h00);
        end
    end

    // Write-back byte with a fresh refresh mask on both shares.
    always_comb begin
        tail_b.s0 = cur_b.s0 ^ rnd_i;
        tail_b.s1 = cur_b.s1 ^ rnd_i;
    end

    // Round-key outputs, zero outside the emission window.
    always_comb begin
        rk_valid_o = emit;
        rk_s0      = emit ? cur_b.s0 : 8'h00;
        rk_s1      = emit ? cur_b.s1 : 8'h00;
    end

    // S-box operand: rotated last column, expanded to three shares.
    always_comb begin
        feed_idx = IDX_W'(LAST_COL) + IDX_W'(feed_row);
        feed_b   = key_q[feed_idx];
        sb_in_s0 = feed ? (feed_b.s0 ^ rnd_i) : 8'h00;
        sb_in_s1 = feed ? feed_b.s1 : 8'h00;
        sb_in_s2 = feed ? rnd_i : 8'h00;
    end

    // S-box result reduced from three shares to two, plus the round constant.
    always_comb begin
        mix_b.s0 = sb_out_s0 ^ sb_out_s2 ^ (rc_fire ? rcon : 8'h00);
        mix_b.s1 = sb_out_s1;
    end

    // R1: idle cycles drive every output to zero.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i == '0) |-> (!rk_valid_o && rk_s0 == 8'h00 && rk_s1 == 8'h00 &&
                           sb_in_s0 == 8'h00 && sb_in_s1 == 8'h00 && sb_in_s2 == 8'h00));
    // R2: during the load round the emitted value equals the supplied key byte.
    a_r2_load_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (first_i && rk_valid_o) |-> ((rk_s0 ^ rk_s1) == (key_in_s0 ^ key_in_s1)));
    // R5: the third operand share is the fresh random byte.
    a_r5_fresh_share: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i >= CNT_W'(ROUND_LEN - 3 - SBOX_LAT) &&
         cyc_i <= CNT_W'(ROUND_LEN - SBOX_LAT)) |-> sb_in_s2 == rnd_i);
    // R7: an idle cycle leaves the stored key untouched.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i == '0) |=> $stable(key_q));
endmodule

// File: tb/kexp_share2_bench.sv
module kexp_share2_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cyc_i = '0;
    logic       first_i = 1'b0;
    logic [7:0] key_in_s0 = '0, key_in_s1 = '0, rnd_i = '0;
    logic [7:0] sb_out_s0, sb_out_s1, sb_out_s2;
    logic [7:0] sb_in_s0, sb_in_s1, sb_in_s2;
    logic       rk_valid_o;
    logic [7:0] rk_s0, rk_s1;

    int total = 0;
    int bad = 0;
    logic [31:0] lf = 32'h1;
    logic [7:0]  ek [0:191];

    always #5 clk = ~clk;

    kexp_share2 u_kexp_share2 (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .first_i(first_i),
        .key_in_s0(key_in_s0), .key_in_s1(key_in_s1), .rnd_i(rnd_i),
        .sb_out_s0(sb_out_s0), .sb_out_s1(sb_out_s1), .sb_out_s2(sb_out_s2),
        .sb_in_s0(sb_in_s0), .sb_in_s1(sb_in_s1), .sb_in_s2(sb_in_s2),
        .rk_valid_o(rk_valid_o), .rk_s0(rk_s0), .rk_s1(rk_s1)
    );

    function automatic logic [7:0] xt(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xt(x);
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int k);
        return (v << k) | (v >> (8 - k));
    endfunction

    function automatic logic [7:0] sbox_f(input logic [7:0] x);
        logic [7:0] p = 8'h01;
        logic [7:0] b = x;
        logic [7:0] e = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) p = gmul(p, b);
            b = gmul(b, b);
        end
        return p ^ rotl(p, 1) ^ rotl(p, 2) ^ rotl(p, 3) ^ rotl(p, 4) ^ 8'h63;
    endfunction

    // S-box model: two-cycle latency, three output shares under a running mask.
    logic [7:0]  sbm;
    logic [23:0] p1, p2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbm <= 8'h00; p1 <= '0; p2 <= '0;
        end else begin
            sbm <= sbm + 8'd37;
            p1  <= {{sbm[3:0], sbm[7:4]}, sbm,
                    sbox_f(sb_in_s0 ^ sb_in_s1 ^ sb_in_s2) ^ sbm ^ {sbm[3:0], sbm[7:4]}};
            p2  <= p1;
        end
    end
    assign sb_out_s0 = p2[7:0];
    assign sb_out_s1 = p2[15:8];
    assign sb_out_s2 = p2[23:16];

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // Reference expansion to twelve round keys, constant wrapping after 36.
    task automatic expand(input logic [127:0] key);
        logic [7:0] rc = 8'h01;
        for (int b = 0; b < 16; b++) ek[b] = key[127 - 8*b -: 8];
        for (int i = 16; i < 192; i++) begin
            int k = i / 4;
            int r = i % 4;
            if (k % 4 == 0) begin
                ek[i] = ek[i-16] ^ sbox_f(ek[4*(k-1) + ((r + 1) % 4)]) ^ (r == 0 ? rc : 8'h00);
                if (r == 3) rc = (rc == 8'h36) ? 8'h01 : xt(rc);
            end else begin
                ek[i] = ek[i-16] ^ ek[i-4];
            end
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] c, input logic f, input logic [7:0] kb);
        @(posedge clk);
        #1;
        lf = nxt(lf);
        cyc_i = c;
        first_i = f;
        key_in_s0 = kb ^ lf[7:0];
        key_in_s1 = lf[7:0];
        rnd_i = lf[15:8];
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(5'd0, lf[16], lf[31:24]);
            chk("R7 idle valid", {7'd0, rk_valid_o}, 8'h00);
            chk("R7 idle key", rk_s0 | rk_s1, 8'h00);
        end
    endtask

    task automatic run_key(input logic [127:0] key, input logic [31:0] seed,
                           input int gap, input logic [127:0] lit, input int nr);
        expand(key);
        lf = seed;
        for (int r = 0; r < nr; r++) begin
            for (int c = 1; c <= 23; c++) begin
                if (r == 11 && c > 16) break;
                step(5'(c), r == 0, (r == 0 && c <= 16) ? key[127 - 8*(c-1) -: 8] : lf[23:16]);
                if (c <= 16) begin
                    chk("R2/R3 valid", {7'd0, rk_valid_o}, 8'h01);
                    if (r == 0)
                        chk("R2 load byte", rk_s0 ^ rk_s1, ek[c-1]);
                    else if (r == 11 && c == 1)
                        chk("R6 wrapped constant", rk_s0 ^ rk_s1, ek[16*r]);
                    else if (c <= 4)
                        chk("R8 merged byte", rk_s0 ^ rk_s1, ek[16*r + c - 1]);
                    else
                        chk("R3 round byte", rk_s0 ^ rk_s1, ek[16*r + c - 1]);
                    if (r == 10 && lit != '0)
                        chk("R3 literal", rk_s0 ^ rk_s1, lit[127 - 8*(c-1) -: 8]);
                    if (r == 1 && c == 1)
                        chk("R6 restart", rk_s0 ^ rk_s1, ek[16]);
                end else if (c >= 18 && c <= 21) begin
                    chk("R4 feed byte", sb_in_s0 ^ sb_in_s1 ^ sb_in_s2,
                        ek[16*r + 12 + ((c - 17) % 4)]);
                    if (c == 18) chk("R5 fresh share", sb_in_s2, rnd_i);
                end else begin
                    chk("R4 feed quiet", sb_in_s0 | sb_in_s1 | sb_in_s2, 8'h00);
                end
                if (c == 16 || c == 23) idle(gap);
            end
        end
    endtask

    typedef struct packed {
        logic [127:0] key;
        logic [127:0] lit;
        logic [31:0]  seed;
        int           gap;
        int           nr;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
          32'h0000_1234, 0, 12},
        '{128'h0, 128'h0, 32'h00c0_ffee, 3, 4},
        '{128'hffffffffffffffffffffffffffffffff, 128'h0, 32'h0bad_f00d, 2, 12},
        '{128'h000102030405060708090a0b0c0d0e0f, 128'h0, 32'h1357_9bdf, 0, 12}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R-all act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", {7'd0, rk_valid_o}, 8'h00);
        chk("R1 reset key", rk_s0 | rk_s1, 8'h00);
        chk("R1 reset sbox", sb_in_s0 | sb_in_s1 | sb_in_s2, 8'h00);

        for (int v = 0; v < 4; v++)
            run_key(VECS[v].key, VECS[v].seed, VECS[v].gap, VECS[v].lit, VECS[v].nr);

        // Reset in the middle of a run, then a fresh full run.
        run_key(128'h00112233445566778899aabbccddeeff, 32'h0000_7777, 1, 128'h0, 3);
        @(posedge clk);
        #1 rst_n = 1'b0; cyc_i = 5'd0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 re-reset valid", {7'd0, rk_valid_o}, 8'h00);
        chk("R1 re-reset sbox", sb_in_s0 | sb_in_s1 | sb_in_s2, 8'h00);
        run_key(VECS[0].key, 32'h0000_9999, 1, VECS[0].lit, 12);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule